// File: doc/BRIEF.md
# Host I/O Port Slave for an 8-bit Expansion Bus

This block lets a host processor on an 8-bit ISA-style expansion bus read and write a small bank of byte registers with plain port input and output instructions. The host side consists of a 10-bit port address, an address-enable qualifier and active-low read and write strobes. The 8-bit data bus is split into an input, an output and an output enable so that the pad ring can build the tristate buffer. The fabric side gives the block a system clock, a synchronous reset and a selectable base address for the block's 32-port window.

The bus strobes have no timing relation to the system clock. A read is answered combinationally from the register bank for as long as the read condition holds. A write is captured in registers clocked by the trailing edge of the write strobe. A toggle flag then carries it through a synchronizer into the clock domain, where it shows up as a one-cycle pulse with offset and data and is committed to the bank. A commit that would land while a synchronized read is in progress waits until the read ends, so the host never sees a register change under its read strobe.

Top module: `isa8_io_slave`

## Requirements
- R1: A bus address is in the window when its bits 9..5 equal bits 9..5 of `base_addr`. Bits 4..0 of `base_addr` are ignored, and bits 4..0 of the bus address select the offset 0..31.
- R2: `bus_data_oe` is high exactly while the address is in the window, `bus_aen` is low and `bus_rd_n` is low. In that state `bus_data_out` shows the byte at the selected offset. Otherwise `bus_data_oe` is low.
- R3: While `bus_aen` is high, the block neither drives the data bus nor captures a write, whatever the address is.
- R4: A low-to-high transition of `bus_wr_n` with the address in the window and `bus_aen` low captures the offset and `bus_data_in`. Within 4 clock cycles this produces exactly one single-cycle `wr_pulse` carrying that offset on `wr_offset` and that byte on `wr_data`.
- R5: Offset 0 reads as the constant `ID_VALUE` (default A5h). A write to offset 0 does not change what it reads.
- R6: Offsets 1 to `NUM_REGS`-1 (default 1..7) are writable and read back the last byte written. Offsets `NUM_REGS`..31 read 00h and ignore writes.
- R7: The register bank does not change while the synchronized read indication is active. A write that arrives during a read is held and committed after the read ends.
- R8: Synchronous reset clears all writable registers to 00h, holds `wr_pulse` low and drops any write still in transit.
- R9: With a base of 200h, 220h, 300h or 320h, accesses to ports 2F8h–2FFh and 3F8h–3FFh get no response: no drive and no write pulse.
- R10: Writes whose strobe rising edges are at least 6 clock periods apart each produce their own pulse and their own register update, with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_addr | input | 10 | Window base; bits 9..5 are used |
| bus_addr | input | 10 | Host port address |
| bus_aen | input | 1 | Address enable; high marks a cycle not meant for I/O slaves |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_wr_n | input | 1 | Active-low write strobe |
| bus_data_in | input | 8 | Data bus as seen from the host |
| bus_data_out | output | 8 | Read data toward the data bus |
| bus_data_oe | output | 1 | Output enable for the data bus buffer |
| wr_pulse | output | 1 | One-cycle pulse for each accepted write |
| wr_offset | output | 5 | Window offset of the accepted write |
| wr_data | output | 8 | Byte of the accepted write |
| ctrl_regs | output | (NUM_REGS-1)*8 | Writable registers; offset 1 occupies the low byte |

## Verification
The checker samples every cycle and confirms four properties: the output enable only appears with an in-window read and a low address enable, unimplemented offsets read zero, the register bank is frozen while a synchronized read lasts, and each write pulse lasts one cycle. Reset clearing is also checked on every cycle. Other behaviour only the bench's scenarios can show. This covers capture on the trailing strobe edge, the correct offset and data on the pulse, deferral of a write that overlaps a read, immunity of the serial-port ranges for each allowed base, and loss-free handling of closely spaced writes. The random phase compares every read against a byte model kept in the bench.

// File: rtl/isa8_pkg.sv
`timescale 1ns/1ps
package isa8_pkg;
    localparam int ADDR_W   = 10;
    localparam int DATA_W   = 8;
    localparam int OFF_W    = 5;
    localparam int WIN_SIZE = 1 << OFF_W;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [ADDR_W-1:0] port_t;

    typedef struct packed {
        off_t  off;
        byte_t data;
    } wr_req_t;

    function automatic logic win_match(input port_t addr, input port_t base);
        return addr[ADDR_W-1:OFF_W] == base[ADDR_W-1:OFF_W];
    endfunction

    function automatic off_t win_offset(input port_t addr);
        return addr[OFF_W-1:0];
    endfunction
endpackage

// File: rtl/isa8_sync.sv
`timescale 1ns/1ps
module isa8_sync #(
    parameter int STAGES   = 2,
    parameter bit RESET_EN = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    generate
        if (RESET_EN) begin : g_rst
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], d};
            end
        end else begin : g_norst
            logic unused_rst;
            assign unused_rst = rst;
            always_ff @(posedge clk) begin
                sh <= {sh[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = sh[STAGES-1];
endmodule

// File: rtl/isa8_decode.sv
`timescale 1ns/1ps
module isa8_decode
    import isa8_pkg::*;
(
    input  port_t base_addr,
    input  port_t bus_addr,
    input  logic  bus_aen,
    input  logic  bus_rd_n,
    output logic  sel,
    output logic  rd_act,
    output off_t  off
);
    logic in_win;

    always_comb begin
        in_win = win_match(bus_addr, base_addr);
        sel    = in_win && !bus_aen;
        rd_act = sel && !bus_rd_n;
        off    = win_offset(bus_addr);
    end
endmodule

// File: rtl/isa8_wr_capture.sv
`timescale 1ns/1ps
module isa8_wr_capture
    import isa8_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    bus_wr_n,
    input  logic    sel,
    input  off_t    bus_off,
    input  byte_t   bus_data,
    output logic    pulse,
    output wr_req_t req
);
    // Strobe domain: clocked by the trailing edge of the write strobe.
    logic    tog;
    wr_req_t cap;

    always_ff @(posedge bus_wr_n) begin
        if (sel) begin
            tog      <= ~tog;
            cap.off  <= bus_off;
            cap.data <= bus_data;
        end
    end

    // Clock domain.
    logic tog_s, tog_d;

    isa8_sync #(.STAGES(SYNC_STAGES), .RESET_EN(1'b0)) u_tog_sync (
        .clk (clk),
        .rst (rst),
        .d   (tog),
        .q   (tog_s)
    );

    always_ff @(posedge clk) begin
        tog_d <= tog_s;
        if (rst) begin
            pulse <= 1'b0;
            req   <= '0;
        end else begin
            pulse <= tog_s ^ tog_d;
            if (tog_s ^ tog_d) req <= cap;
        end
    end
endmodule

// File: rtl/isa8_reg_bank.sv
`timescale 1ns/1ps
module isa8_reg_bank
    import isa8_pkg::*;
#(
    parameter int    NUM_REGS = 8,
    parameter byte_t ID_VALUE = 8'hA5,
    localparam int   N_RW     = NUM_REGS - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_busy,
    input  logic             wr_pulse,
    input  wr_req_t          wr_req,
    input  off_t             rd_off,
    output byte_t            rd_data,
    output logic [N_RW*8-1:0] regs_flat
);
    wr_req_t pend;
    logic    pend_v;
    logic    commit;
    byte_t   regs_q [N_RW];

    assign commit = pend_v && !rd_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v <= 1'b0;
            pend   <= '0;
        end else begin
            if (wr_pulse) begin
                pend_v <= 1'b1;
                pend   <= wr_req;
            end else if (commit) begin
                pend_v <= 1'b0;
            end
        end
    end

    generate
        for (genvar g = 0; g < N_RW; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs_q[g] <= '0;
                else if (commit && pend.off == off_t'(g + 1))
                    regs_q[g] <= pend.data;
            end
            assign regs_flat[g*8 +: 8] = regs_q[g];
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        if (rd_off == '0) rd_data = ID_VALUE;
        for (int i = 0; i < N_RW; i++) begin
            if (rd_off == off_t'(i + 1)) rd_data = regs_q[i];
        end
    end
endmodule

// File: rtl/isa8_io_slave.sv
`timescale 1ns/1ps
module isa8_io_slave
    import isa8_pkg::*;
#(
    parameter int        NUM_REGS    = 8,
    parameter bit [7:0]  ID_VALUE    = 8'hA5,
    parameter int        SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [9:0]                base_addr,
    input  logic [9:0]                bus_addr,
    input  logic                      bus_aen,
    input  logic                      bus_rd_n,
    input  logic                      bus_wr_n,
    input  logic [7:0]                bus_data_in,
    output logic [7:0]                bus_data_out,
    output logic                      bus_data_oe,
    output logic                      wr_pulse,
    output logic [4:0]                wr_offset,
    output logic [7:0]                wr_data,
    output logic [(NUM_REGS-1)*8-1:0] ctrl_regs
);
    logic    sel, rd_act, rd_busy;
    off_t    off;
    wr_req_t req;
    byte_t   rd_data;

    isa8_decode u_decode (
        .base_addr (base_addr),
        .bus_addr  (bus_addr),
        .bus_aen   (bus_aen),
        .bus_rd_n  (bus_rd_n),
        .sel       (sel),
        .rd_act    (rd_act),
        .off       (off)
    );

    isa8_wr_capture #(.SYNC_STAGES(SYNC_STAGES)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .bus_wr_n (bus_wr_n),
        .sel      (sel),
        .bus_off  (off),
        .bus_data (bus_data_in),
        .pulse    (wr_pulse),
        .req      (req)
    );

    isa8_sync #(.STAGES(SYNC_STAGES), .RESET_EN(1'b1)) u_rd_sync (
        .clk (clk),
        .rst (rst),
        .d   (rd_act),
        .q   (rd_busy)
    );

    isa8_reg_bank #(.NUM_REGS(NUM_REGS), .ID_VALUE(ID_VALUE)) u_bank (
        .clk       (clk),
        .rst       (rst),
        .rd_busy   (rd_busy),
        .wr_pulse  (wr_pulse),
        .wr_req    (req),
        .rd_off    (off),
        .rd_data   (rd_data),
        .regs_flat (ctrl_regs)
    );

    assign bus_data_oe  = rd_act;
    assign bus_data_out = rd_act ? rd_data : '0;
    assign wr_offset    = req.off;
    assign wr_data      = req.data;
endmodule

// File: rtl/isa8_io_slave_chk.sv
`timescale 1ns/1ps
module isa8_io_slave_chk #(
    parameter int NUM_REGS = 8
) (
    input logic                      clk,
    input logic                      rst,
    input logic [9:0]                base_addr,
    input logic [9:0]                bus_addr,
    input logic                      bus_aen,
    input logic                      bus_rd_n,
    input logic [7:0]                bus_data_out,
    input logic                      bus_data_oe,
    input logic                      wr_pulse,
    input logic                      rd_busy,
    input logic [(NUM_REGS-1)*8-1:0] ctrl_regs
);
    AST_OE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        bus_data_oe |-> (!bus_rd_n && bus_addr[9:5] == base_addr[9:5])); // R2

    AST_AEN_SILENT: assert property (@(posedge clk) disable iff (rst)
        bus_aen |-> !bus_data_oe); // R3

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wr_pulse |=> !wr_pulse); // R4

    AST_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_data_oe && 32'(bus_addr[4:0]) >= NUM_REGS) |-> bus_data_out == 8'h00); // R6

    AST_NO_TEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rd_busy) |-> $stable(ctrl_regs)); // R7

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!wr_pulse && ctrl_regs == '0)); // R8
endmodule

bind isa8_io_slave isa8_io_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .base_addr    (base_addr),
    .bus_addr     (bus_addr),
    .bus_aen      (bus_aen),
    .bus_rd_n     (bus_rd_n),
    .bus_data_out (bus_data_out),
    .bus_data_oe  (bus_data_oe),
    .wr_pulse     (wr_pulse),
    .rd_busy      (rd_busy),
    .ctrl_regs    (ctrl_regs)
);

// File: tb/test_isa8_io_slave.sv
`timescale 1ns/1ps
module test_isa8_io_slave;
    localparam int NREG = 8;
    localparam logic [7:0] ID = 8'hA5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [9:0] base_addr = 10'h300;
    logic [9:0] bus_addr = 10'h000;
    logic bus_aen = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [7:0] bus_data_in = 8'h00;
    logic [7:0] bus_data_out;
    logic bus_data_oe, wr_pulse;
    logic [4:0] wr_offset;
    logic [7:0] wr_data;
    logic [(NREG-1)*8-1:0] ctrl_regs;

    int checks = 0, fails = 0;
    int pulse_cnt = 0;
    logic [4:0] last_off;
    logic [7:0] last_data;
    logic [7:0] model [32];
    bit done = 0;

    always #2 clk = ~clk;

    isa8_io_slave i_isa8_io_slave (
        .clk(clk), .rst(rst), .base_addr(base_addr), .bus_addr(bus_addr),
        .bus_aen(bus_aen), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_data_in(bus_data_in), .bus_data_out(bus_data_out),
        .bus_data_oe(bus_data_oe), .wr_pulse(wr_pulse), .wr_offset(wr_offset),
        .wr_data(wr_data), .ctrl_regs(ctrl_regs)
    );

    always @(negedge clk) begin
        if (wr_pulse) begin
            pulse_cnt <= pulse_cnt + 1;
            last_off  <= wr_offset;
            last_data <= wr_data;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [4:0] off);
        if (off == 5'd0) return ID;
        if (int'(off) < NREG) return model[off];
        return 8'h00;
    endfunction

    task automatic host_write(input logic [9:0] a, input logic [7:0] d, input logic aen);
        bus_addr = a; bus_aen = aen; bus_data_in = d;
        #5.3 bus_wr_n = 1'b0;
        #20.1 bus_wr_n = 1'b1;
        #3.1 bus_aen = 1'b1; bus_addr = 10'h000;
        #40;
    endtask

    task automatic host_read(input logic [9:0] a, input logic aen,
                             output logic [7:0] d, output logic oe);
        bus_addr = a; bus_aen = aen;
        #3.7 bus_rd_n = 1'b0;
        #15.2 d = bus_data_out; oe = bus_data_oe;
        bus_rd_n = 1'b1;
        #2.9 bus_aen = 1'b1; bus_addr = 10'h000;
        #10;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic oe;
        int pc;
        void'($urandom(1234));
        for (int i = 0; i < 32; i++) model[i] = 8'h00;

        repeat (5) @(posedge clk);
        #0.7 rst = 1'b0;
        #1;
        check(wr_pulse == 0 && bus_data_oe == 0, "R8 reset idle", {wr_pulse, bus_data_oe}, 0);
        check(ctrl_regs == '0, "R8 reset regs", int'(ctrl_regs[31:0]), 0);

        // R5 identification byte
        host_read(10'h300, 0, d, oe);
        check(oe && d == ID, "R5 id read", d, ID);
        pc = pulse_cnt;
        host_write(10'h300, 8'h3C, 0);
        check(pulse_cnt == pc + 1 && last_off == 0 && last_data == 8'h3C, "R4 pulse for offset0", last_data, 8'h3C);
        host_read(10'h300, 0, d, oe);
        check(d == ID, "R5 id unchanged", d, ID);

        // R4 / R6 write and readback
        pc = pulse_cnt;
        host_write(10'h303, 8'h5A, 0); model[3] = 8'h5A;
        check(pulse_cnt == pc + 1, "R4 one pulse", pulse_cnt - pc, 1);
        check(last_off == 5'd3 && last_data == 8'h5A, "R4 pulse payload", {last_off, last_data}, {5'd3, 8'h5A});
        host_read(10'h303, 0, d, oe);
        check(oe && d == 8'h5A, "R6 readback", d, 8'h5A);
        host_write(10'h31A, 8'hEE, 0);
        host_read(10'h31A, 0, d, oe);
        check(oe && d == 8'h00, "R6 unimplemented reads zero", d, 0);

        // R3 AEN high
        pc = pulse_cnt;
        host_write(10'h303, 8'h11, 1);
        check(pulse_cnt == pc, "R3 no pulse with aen", pulse_cnt - pc, 0);
        host_read(10'h303, 1, d, oe);
        check(!oe, "R3 no drive with aen", oe, 0);
        host_read(10'h303, 0, d, oe);
        check(d == 8'h5A, "R3 register untouched", d, 8'h5A);

        // R1 base low bits ignored
        base_addr = 10'h30F;
        host_read(10'h303, 0, d, oe);
        check(oe && d == 8'h5A, "R1 base low bits ignored", d, 8'h5A);
        host_read(10'h2E3, 0, d, oe);
        check(!oe, "R1 outside window", oe, 0);

        // R9 serial port ranges never answered
        for (int b = 0; b < 4; b++) begin
            logic [9:0] bases [4] = '{10'h200, 10'h220, 10'h300, 10'h320};
            base_addr = bases[b];
            pc = pulse_cnt;
            host_write(10'h2F8 + 10'(b), 8'h77, 0);
            host_write(10'h3F8 + 10'(b), 8'h77, 0);
            check(pulse_cnt == pc, "R9 no write pulse", pulse_cnt - pc, 0);
            host_read(10'h3FF - 10'(b), 0, d, oe);
            check(!oe, "R9 no drive 3F8h range", oe, 0);
            host_read(10'h2FC, 0, d, oe);
            check(!oe, "R9 no drive 2F8h range", oe, 0);
        end

        // R7 write arriving during a read is deferred
        base_addr = 10'h220;
        bus_addr = 10'h225; bus_aen = 0; bus_data_in = 8'hC3;
        #3.3 bus_wr_n = 0;
        #20 bus_wr_n = 1;
        #0.5 bus_rd_n = 0;
        #60 d = bus_data_out;
        check(d == 8'h00, "R7 value frozen during read", d, 0);
        check(ctrl_regs[4*8 +: 8] == 8'h00, "R7 bank frozen", ctrl_regs[4*8 +: 8], 0);
        bus_rd_n = 1;
        #2.1 bus_aen = 1;
        #30; model[5] = 8'hC3;
        host_read(10'h225, 0, d, oe);
        check(d == 8'hC3, "R7 committed after read", d, 8'hC3);

        // R10 closely spaced writes
        pc = pulse_cnt;
        bus_aen = 0;
        for (int k = 0; k < 3; k++) begin
            bus_addr = 10'h221 + 10'(k); bus_data_in = 8'h90 + 8'(k);
            #2.2 bus_wr_n = 0;
            #10 bus_wr_n = 1;
            #13.1;
            model[1 + k] = 8'h90 + 8'(k);
        end
        bus_aen = 1;
        #40;
        check(pulse_cnt == pc + 3, "R10 three pulses", pulse_cnt - pc, 3);
        for (int k = 0; k < 3; k++) begin
            host_read(10'h221 + 10'(k), 0, d, oe);
            check(d == model[1 + k], "R10 readback", d, model[1 + k]);
        end

        // Random phase against the model
        for (int n = 0; n < 80; n++) begin
            logic [9:0] bases [4] = '{10'h200, 10'h220, 10'h300, 10'h320};
            logic [4:0] off = 5'($urandom_range(0, 31));
            logic a = ($urandom_range(0, 4) == 0);
            logic [7:0] v = 8'($urandom);
            base_addr = bases[$urandom_range(0, 3)];
            if ($urandom_range(0, 1) == 1) begin
                pc = pulse_cnt;
                host_write(base_addr + 10'(off), v, a);
                if (!a && off != 0 && int'(off) < NREG) model[off] = v;
                check(pulse_cnt == pc + (a ? 0 : 1), a ? "R3 random aen write" : "R4 random write",
                      pulse_cnt - pc, a ? 0 : 1);
            end else begin
                host_read(base_addr + 10'(off), a, d, oe);
                if (a) check(!oe, "R3 random aen read", oe, 0);
                else   check(oe && d == exp_read(off), "R2 random read", d, exp_read(off));
            end
        end

        // R8 reset clears bank and drops write in transit
        bus_addr = 10'h222; bus_aen = 0; bus_data_in = 8'h44; base_addr = 10'h220;
        #1 bus_wr_n = 0;
        #10 bus_wr_n = 1;
        #0.3 rst = 1; bus_aen = 1;
        pc = pulse_cnt;
        repeat (6) @(posedge clk);
        #0.7 rst = 0;
        repeat (6) @(posedge clk);
        #1;
        check(pulse_cnt == pc, "R8 pending write dropped", pulse_cnt - pc, 0);
        check(ctrl_regs == '0, "R8 bank cleared", int'(ctrl_regs[31:0]), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule